// File: doc/BRIEF.md
# Interrupt and Trap Control Unit

This block owns the processor status word and decides, every cycle, whether the core has to leave its current instruction stream. Interrupt sources raise or drop their own pending bits through a per-source write strobe. Software sets per-source mask bits, a global enable and the privilege/mode bits with a status write. An exception request from the pipeline carries a small cause code and always beats a pending interrupt.

When a trap is taken, the unit records the cause and saves the current PC into the exception PC register. It stacks the privilege and enable bits into their "previous" copies, enters supervisor mode with interrupts off, and drives the trap vector out as the next PC together with a one-cycle redirect strobe. For an interrupt, the cause is the winning source index with a flag bit set. That flag sits at bit 63 while supervisor 64-bit mode is on and at bit 31 otherwise. Build options remove 64-bit mode, floating-point enable and accelerator enable, and status writes then force those bits to zero.

Status layout with default parameters (32 bits):
- bit 0: interrupt enable
- bit 1: previous enable
- bit 2: supervisor
- bit 3: previous supervisor
- bit 4: FP enable
- bit 5: accelerator enable
- bit 6: supervisor 64-bit
- bit 7: user 64-bit
- bit 8: translation enable
- bits 15:9: reserved and read as zero
- bits 23:16: pending, one bit per source
- bits 31:24: mask, one bit per source

Top module: `trap_ctl`

## Requirements
- R1: After reset, pc_o is 0x2000, status_o is 0x44 (supervisor and supervisor 64-bit set, enable, translation, pending and mask clear), and redirect_o, epc_o and cause_o are zero.
- R2: An interrupt trap is taken only when status bit 0 is set and some source has both its pending bit (16+i) and its mask bit (24+i) set. Otherwise no redirect occurs.
- R3: When several sources qualify, the lowest-numbered source is taken.
- R4: An interrupt's cause_o is the source index with bit 63 set if status bit 6 is 1, and with bit 31 set (bit 63 clear) if it is 0.
- R5: On any trap, status bit 3 takes the old bit 2 and bit 1 takes the old bit 0; then bit 2 is set and bit 0 cleared.
- R6: On any trap, epc_o takes cur_pc of the trap cycle and pc_o takes the trap vector register (sw_sel=2). The cause and these values appear one clock after the trap cycle.
- R7: A status write (sw_we with sw_sel=0) leaves the pending field 23:16 unchanged, whatever the data.
- R8: With default options (64-bit on, no FP unit, no accelerator), a status write forces bits 4, 5 and 15:9 to zero and stores the others as written.
- R9: irq_wr[i] loads irq_lvl[i] into pending bit 16+i only. Sources whose strobe is low keep their bit.
- R10: An exception request beats a qualifying interrupt in the same cycle. cause_o is then exc_code zero-extended.
- R11: redirect_o is high for exactly the one cycle after each trap cycle, and low when no trap was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | XLEN | PC of the instruction in the trap cycle |
| exc_req | input | 1 | Exception request |
| exc_code | input | CODE_W | Exception cause code |
| irq_wr | input | NUM_IRQ | Per-source pending write strobe |
| irq_lvl | input | NUM_IRQ | Per-source pending value |
| sw_we | input | 1 | Software register write |
| sw_sel | input | 2 | 0 status, 1 exception PC, 2 trap vector |
| sw_wdata | input | XLEN | Software write data |
| status_o | output | 16+2*NUM_IRQ | Status word |
| epc_o | output | XLEN | Exception PC |
| cause_o | output | XLEN | Trap cause |
| pc_o | output | XLEN | Next PC |
| redirect_o | output | 1 | Next PC valid strobe |

## Verification
The hardest case to reach is two traps back to back, where the second trap stacks the privilege bits that the first one just wrote. The bench starts from user mode with enable set and holds exc_req for two consecutive cycles. It then checks the previous bits after each trap. The same-cycle race between an exception and a qualifying interrupt is reached by arming an interrupt with a status write and raising exc_req on the very next edge.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int IE_B       = 0;
   localparam int PIE_B      = 1;
   localparam int SV_B       = 2;
   localparam int PSV_B      = 3;
   localparam int FPU_B      = 4;
   localparam int ACC_B      = 5;
   localparam int S64_B      = 6;
   localparam int U64_B      = 7;
   localparam int VM_B       = 8;
   localparam int PEND_SHIFT = 16;

   localparam logic [1:0] SEL_STATUS = 2'd0;
   localparam logic [1:0] SEL_EPC    = 2'd1;
   localparam logic [1:0] SEL_EVEC   = 2'd2;

   // bits of the low status field that a software write may set
   function automatic logic [PEND_SHIFT-1:0] wr_keep(bit has64, bit hasfpu, bit hasext);
      logic [PEND_SHIFT-1:0] k;
      k        = '0;
      k[IE_B]  = 1'b1;
      k[PIE_B] = 1'b1;
      k[SV_B]  = 1'b1;
      k[PSV_B] = 1'b1;
      k[VM_B]  = 1'b1;
      k[FPU_B] = hasfpu;
      k[ACC_B] = hasext;
      k[S64_B] = has64;
      k[U64_B] = has64;
      return k;
   endfunction

   function automatic logic [PEND_SHIFT-1:0] reset_base(bit has64);
      logic [PEND_SHIFT-1:0] r;
      r        = '0;
      r[SV_B]  = 1'b1;
      r[S64_B] = has64;
      return r;
   endfunction
endpackage

// File: rtl/trap_irq_arb.sv
module trap_irq_arb #(
   parameter int N     = 8,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     pend_i,
   input  logic [N-1:0]     mask_i,
   input  logic             ie_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N-1:0]     grant_o
);
   logic [N-1:0] req;

   always_comb begin
      req     = pend_i & mask_i;
      valid_o = ie_i && (|req);
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx_o = IDX_W'(i);
      end
      grant_o = '0;
      if (valid_o) grant_o[idx_o] = 1'b1;
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)); // R3
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o != '0) |-> (((pend_i & mask_i) & (grant_o - N'(1))) == '0)); // R3
   AST_GATED_BY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o != '0) |-> ((grant_o & ~(pend_i & mask_i)) == '0)); // R2
endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg import trap_pkg::*; #(
   parameter int N        = 8,
   parameter int HAS_RV64 = 1,
   parameter int HAS_FPU  = 0,
   parameter int HAS_EXT  = 0,
   localparam int SW      = PEND_SHIFT + 2 * N
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          irq_wr,
   input  logic [N-1:0]          irq_lvl,
   input  logic                  sw_we,
   input  logic [PEND_SHIFT-1:0] sw_base,
   input  logic [N-1:0]          sw_mask,
   input  logic                  trap_en,
   output logic [SW-1:0]         status_o
);
   localparam logic [PEND_SHIFT-1:0] KEEP =
      wr_keep(HAS_RV64 != 0, HAS_FPU != 0, HAS_EXT != 0);
   localparam logic [PEND_SHIFT-1:0] RST = reset_base(HAS_RV64 != 0);

   logic [PEND_SHIFT-1:0] base_q;
   logic [N-1:0]          pend_q;
   logic [N-1:0]          mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= RST;
         mask_q <= '0;
      end else if (trap_en) begin
         base_q[PSV_B] <= base_q[SV_B];
         base_q[PIE_B] <= base_q[IE_B];
         base_q[SV_B]  <= 1'b1;
         base_q[IE_B]  <= 1'b0;
      end else if (sw_we) begin
         base_q <= sw_base & KEEP;
         mask_q <= sw_mask;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_pend
      always_ff @(posedge clk) begin
         if (!rst_n)         pend_q[i] <= 1'b0;
         else if (irq_wr[i]) pend_q[i] <= irq_lvl[i];
      end
   end

   assign status_o = {mask_q, pend_q, base_q};

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && (irq_wr == '0)) |=> (pend_q == $past(pend_q))); // R7
   AST_TRAP_STACK: assert property (@(posedge clk) disable iff (!rst_n)
      trap_en |=> (base_q[SV_B] && !base_q[IE_B]
                   && base_q[PSV_B] == $past(base_q[SV_B])
                   && base_q[PIE_B] == $past(base_q[IE_B]))); // R5
   AST_OPT_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !trap_en) |=> ((base_q & ~KEEP) == '0)); // R8
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl import trap_pkg::*; #(
   parameter int              XLEN     = 64,
   parameter int              NUM_IRQ  = 8,
   parameter int              CODE_W   = 5,
   parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h2000),
   parameter int              HAS_RV64 = 1,
   parameter int              HAS_FPU  = 0,
   parameter int              HAS_EXT  = 0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [XLEN-1:0]                 cur_pc,
   input  logic                            exc_req,
   input  logic [CODE_W-1:0]               exc_code,
   input  logic [NUM_IRQ-1:0]              irq_wr,
   input  logic [NUM_IRQ-1:0]              irq_lvl,
   input  logic                            sw_we,
   input  logic [1:0]                      sw_sel,
   input  logic [XLEN-1:0]                 sw_wdata,
   output logic [PEND_SHIFT+2*NUM_IRQ-1:0] status_o,
   output logic [XLEN-1:0]                 epc_o,
   output logic [XLEN-1:0]                 cause_o,
   output logic [XLEN-1:0]                 pc_o,
   output logic                            redirect_o
);
   localparam int STAT_W     = PEND_SHIFT + 2 * NUM_IRQ;
   localparam int IDX_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
   localparam int MASK_SHIFT = PEND_SHIFT + NUM_IRQ;

   initial begin
      assert (XLEN == 32 || XLEN == 64) else $error("XLEN must be 32 or 64");
      assert (XLEN == 64 || HAS_RV64 == 0) else $error("64-bit mode needs XLEN 64");
      assert (STAT_W <= 32) else $error("status word wider than 32 bits");
      assert (CODE_W >= IDX_W && CODE_W < 31) else $error("bad CODE_W");
      assert (NUM_IRQ >= 1) else $error("need at least one source");
   end

   logic             irq_valid;
   logic [IDX_W-1:0] irq_idx;
   logic [NUM_IRQ-1:0] irq_grant;
   logic             trap_take;
   logic             sw_status;
   logic [XLEN-1:0]  irq_cause;
   logic [XLEN-1:0]  cause_next;
   logic [XLEN-1:0]  evec_q;

   trap_irq_arb #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (status_o[PEND_SHIFT +: NUM_IRQ]),
      .mask_i  (status_o[MASK_SHIFT +: NUM_IRQ]),
      .ie_i    (status_o[IE_B]),
      .valid_o (irq_valid),
      .idx_o   (irq_idx),
      .grant_o (irq_grant)
   );

   assign trap_take = exc_req || irq_valid;
   assign sw_status = sw_we && (sw_sel == SEL_STATUS);

   trap_status_reg #(
      .N(NUM_IRQ), .HAS_RV64(HAS_RV64), .HAS_FPU(HAS_FPU), .HAS_EXT(HAS_EXT)
   ) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_wr   (irq_wr),
      .irq_lvl  (irq_lvl),
      .sw_we    (sw_status),
      .sw_base  (sw_wdata[PEND_SHIFT-1:0]),
      .sw_mask  (sw_wdata[MASK_SHIFT +: NUM_IRQ]),
      .trap_en  (trap_take),
      .status_o (status_o)
   );

   // flag position of an interrupt cause depends on datapath width and mode
   if (XLEN > 32) begin : g_wide
      always_comb begin
         irq_cause = XLEN'(irq_idx);
         if (status_o[S64_B]) irq_cause[XLEN-1] = 1'b1;
         else                 irq_cause[31]     = 1'b1;
      end
   end else begin : g_narrow
      always_comb begin
         irq_cause = XLEN'(irq_idx);
         irq_cause[XLEN-1] = 1'b1;
      end
   end

   assign cause_next = exc_req ? XLEN'(exc_code) : irq_cause;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_o      <= '0;
         evec_q     <= '0;
         cause_o    <= '0;
         pc_o       <= RESET_PC;
         redirect_o <= 1'b0;
      end else begin
         redirect_o <= trap_take;
         if (trap_take) begin
            cause_o <= cause_next;
            epc_o   <= cur_pc;
            pc_o    <= evec_q;
         end else if (sw_we && sw_sel == SEL_EPC) begin
            epc_o <= sw_wdata;
         end
         if (sw_we && sw_sel == SEL_EVEC) evec_q <= sw_wdata;
      end
   end

   AST_EPC_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> (epc_o == $past(cur_pc))); // R6
   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> (!redirect_o || $past(exc_req))); // R11
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> ($past(exc_req) || $past(irq_grant) != '0)); // R2
   AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && $past(exc_req)) |-> (cause_o == XLEN'($past(exc_code)))); // R10
   AST_TRAP_SUPV: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> (status_o[SV_B] && !status_o[IE_B])); // R5
endmodule

// File: tb/sim_trap_ctl.sv
`timescale 1ns/1ps
module sim_trap_ctl;
   localparam int XLEN = 64;
   localparam int N    = 8;

   localparam logic [63:0] B_IE  = 64'h1;
   localparam logic [63:0] B_SV  = 64'h4;
   localparam logic [63:0] B_S64 = 64'h40;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [63:0]     cur_pc = '0;
   logic            exc_req = 1'b0;
   logic [4:0]      exc_code = '0;
   logic [N-1:0]    irq_wr = '0;
   logic [N-1:0]    irq_lvl = '0;
   logic            sw_we = 1'b0;
   logic [1:0]      sw_sel = '0;
   logic [63:0]     sw_wdata = '0;
   logic [31:0]     status_o;
   logic [63:0]     epc_o;
   logic [63:0]     cause_o;
   logic [63:0]     pc_o;
   logic            redirect_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   trap_ctl u0 (
      .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .exc_req(exc_req),
      .exc_code(exc_code), .irq_wr(irq_wr), .irq_lvl(irq_lvl),
      .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
      .status_o(status_o), .epc_o(epc_o), .cause_o(cause_o),
      .pc_o(pc_o), .redirect_o(redirect_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      exc_req = 1'b0; irq_wr = '0; irq_lvl = '0; sw_we = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
   endtask

   task automatic sw_write(input logic [1:0] sel, input logic [63:0] d);
      sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
      cyc();
      sw_we = 1'b0;
   endtask

   task automatic irq_drive(input logic [N-1:0] wr, input logic [N-1:0] lvl);
      irq_wr = wr; irq_lvl = lvl;
      cyc();
      irq_wr = '0; irq_lvl = '0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "status", 64'(status_o), 64'h44);
      chk("R1", "pc", pc_o, 64'h2000);
      chk("R1", "redirect", 64'(redirect_o), 64'h0);
      chk("R1", "epc", epc_o, 64'h0);
      chk("R1", "cause", cause_o, 64'h0);
   endtask

   task automatic t_pending();
      do_reset();
      irq_drive(8'h08, 8'h08);
      chk("R9", "set src3", 64'(status_o), 64'h44 | (64'h1 << 19));
      irq_drive(8'h48, 8'h40);
      chk("R9", "set6 clr3", 64'(status_o), 64'h44 | (64'h1 << 22));
      irq_drive(8'h00, 8'hFF);
      chk("R9", "no strobe", 64'(status_o), 64'h44 | (64'h1 << 22));
   endtask

   task automatic t_mask();
      do_reset();
      sw_write(2'd2, 64'h8000_0100);
      cur_pc = 64'h1234;
      irq_drive(8'h04, 8'h04);
      sw_write(2'd0, B_SV | B_S64 | B_IE);
      cyc();
      chk("R2", "mask clear no trap", 64'(redirect_o), 64'h0);
      sw_write(2'd0, B_SV | B_S64 | (64'h1 << 26));
      cyc();
      chk("R2", "enable clear no trap", 64'(redirect_o), 64'h0);
      sw_write(2'd0, B_SV | B_S64 | B_IE | (64'h1 << 26));
      cyc();
      chk("R11", "redirect", 64'(redirect_o), 64'h1);
      chk("R4", "cause 64", cause_o, 64'h8000_0000_0000_0002);
      chk("R6", "epc", epc_o, 64'h1234);
      chk("R6", "pc vector", pc_o, 64'h8000_0100);
      cyc();
      chk("R11", "pulse ends", 64'(redirect_o), 64'h0);
   endtask

   task automatic t_priority();
      do_reset();
      irq_drive(8'h62, 8'h62);
      sw_write(2'd0, B_SV | B_S64 | B_IE | (64'hFF << 24));
      cyc();
      chk("R3", "lowest of 1,5,6", cause_o, 64'h8000_0000_0000_0001);
      irq_drive(8'h02, 8'h00);
      sw_write(2'd0, B_SV | B_S64 | B_IE | (64'hFF << 24));
      cyc();
      chk("R3", "lowest of 5,6", cause_o, 64'h8000_0000_0000_0005);
      sw_write(2'd0, B_SV | B_S64 | B_IE | (64'h40 << 24));
      cyc();
      chk("R2", "src5 masked", cause_o, 64'h8000_0000_0000_0006);
   endtask

   task automatic t_flag32();
      do_reset();
      irq_drive(8'h80, 8'h80);
      sw_write(2'd0, B_SV | B_IE | (64'h80 << 24));
      cyc();
      chk("R4", "cause 32 flag", cause_o, 64'h0000_0000_8000_0007);
   endtask

   task automatic t_exc_first();
      do_reset();
      irq_drive(8'h01, 8'h01);
      sw_write(2'd0, B_SV | B_S64 | B_IE | (64'h01 << 24));
      exc_req = 1'b1; exc_code = 5'd13;
      cyc();
      exc_req = 1'b0;
      chk("R10", "redirect", 64'(redirect_o), 64'h1);
      chk("R10", "exception wins", cause_o, 64'd13);
   endtask

   task automatic t_nested();
      do_reset();
      sw_write(2'd2, 64'h900);
      sw_write(2'd0, B_S64 | B_IE);
      cur_pc = 64'h400; exc_req = 1'b1; exc_code = 5'd2;
      cyc();
      chk("R5", "first trap status", 64'(status_o), 64'h46);
      chk("R6", "first epc", epc_o, 64'h400);
      cur_pc = 64'h500; exc_code = 5'd3;
      cyc();
      exc_req = 1'b0;
      chk("R5", "second trap status", 64'(status_o), 64'h4C);
      chk("R6", "second epc", epc_o, 64'h500);
      chk("R6", "second pc", pc_o, 64'h900);
      chk("R11", "still high", 64'(redirect_o), 64'h1);
      cyc();
      chk("R11", "drops", 64'(redirect_o), 64'h0);
   endtask

   task automatic t_write_rules();
      do_reset();
      irq_drive(8'hA5, 8'hA5);
      sw_write(2'd0, 64'h0);
      chk("R7", "zero write keeps pending", 64'(status_o), 64'h00A5_0000);
      sw_write(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R8", "ones write forced bits", 64'(status_o), 64'hFFA5_01CF);
   endtask

   initial begin
      t_reset();
      t_pending();
      t_mask();
      t_priority();
      t_flag32();
      t_exc_first();
      t_nested();
      t_write_rules();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule